// File: doc/BRIEF.md
# Oscillator Frequency Monitor

The block measures the frequency of one of several free-running oscillators. Software picks an oscillator with a ring-select field, writes a window length counted in reference-clock cycles, and then raises START while ENABLE is already high. The block clears its edge counter and opens a counting window. It counts rising edges of the selected oscillator in that oscillator's own clock domain, in Gray code. When the window closes, it waits a fixed settle time, latches the synchronised count into a result register, and raises a done flag.

The nominal reference is 24 MHz, so a window of T microseconds is programmed as T×24. The count divided by the window time gives the oscillator frequency. Each control write carries a per-bit write mask in its upper half, so one field can change without a read-modify-write. Clearing START or ENABLE stops a measurement in progress.

Top module: `osc_freq_monitor`

## Requirements
- R1: Control lives at address 0x04 and reads back as bits [4:0]: bit 0 START, bit 1 ENABLE, bits [4:2] ring select. A write changes control bit n only when write-data bit 16+n is 1; every other bit keeps its old value.
- R2: After reset, the control, window, status and result registers all read as zero. Unmapped addresses also read zero.
- R3: The window register at 0x08 is 32 bits wide and reads back the value last written.
- R4: The result at 0x84 equals the rising edges of the selected oscillator during a window of W reference cycles, within ±3 edges.
- R5: Done is status bit 0 at address 0x80. Count the write that creates the START rising edge (with ENABLE high) as edge E0. Done is still low after edge E0+1+W+SETTLE and reads 1 after edge E0+2+W+SETTLE.
- R6: A new START rising edge with ENABLE high clears done by the edge after the write. Done then stays low until that measurement completes.
- R7: A START rising edge while ENABLE is low starts nothing: done stays low and the result is unchanged.
- R8: Clearing START (or ENABLE) before capture aborts the measurement. Done stays low and the result keeps its previous value.
- R9: If START is cleared in the very cycle the result is captured, the measurement completes with done high. If START is cleared one edge earlier, it aborts.
- R10: A ring select of 7 or more selects no oscillator, and the result is exactly 0.
- R11: The edge counter is CNT_W bits wide and saturates at 2^CNT_W−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (window timer and register bus) |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | NUM_OSC | Oscillator inputs, each treated as a clock |
| bus_wr | input | 1 | Write strobe, sampled on the rising clk edge |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data; bits [20:16] are the control write mask |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
Two events can fall in the same cycle: the capture that completes a measurement and a control write that clears START. The bench counts reference edges from the START write. It lands the clearing write exactly on the capture edge, and then one edge earlier, using a short window. It expects done high in the first case and done low with the old result in the second. A restart that lands on a completed result is also checked: done must drop the edge after the write.

// File: rtl/osc_freq_monitor.sv
module osc_freq_monitor #(
  parameter int NUM_OSC = 7,
  parameter int CNT_W   = 32,
  parameter int SETTLE  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OSC-1:0] osc_in,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata
);
  localparam int ST_W = $clog2(SETTLE + 1);
  localparam logic [7:0] A_CTRL = 8'h04, A_WIN = 8'h08, A_STAT = 8'h80, A_RES = 8'h84;

  typedef enum logic [1:0] {S_IDLE, S_CLR, S_RUN, S_SET} state_t;

  logic [4:0]      ctrl_q;
  logic [31:0]     win_q, timer_q, result_q;
  logic            done_q, start_d, gate_q, clr_q;
  logic [ST_W-1:0] scnt_q;
  state_t          state_q;

  wire active     = ctrl_q[0] & ctrl_q[1];
  wire start_rise = active & ~start_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL)
        ctrl_q <= (bus_wdata[4:0] & bus_wdata[20:16]) | (ctrl_q & ~bus_wdata[20:16]);
      if (bus_addr == A_WIN)
        win_q <= bus_wdata;
    end
  end

  // oscillator side
  logic [7:0]       osc_pad;
  logic             osc_clk, osc_rst_n, g1, g2;
  logic [CNT_W-1:0] bin_q, gray_q;
  wire  [CNT_W-1:0] bin_inc = bin_q + 1'b1;

  assign osc_pad   = 8'(osc_in);
  assign osc_clk   = (ctrl_q[4:2] < 3'(NUM_OSC)) ? osc_pad[ctrl_q[4:2]] : 1'b0;
  assign osc_rst_n = rst_n & ~clr_q;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      g1     <= 1'b0;
      g2     <= 1'b0;
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      g1 <= gate_q;
      g2 <= g1;
      if (g2 && !(&bin_q)) begin
        bin_q  <= bin_inc;
        gray_q <= bin_inc ^ (bin_inc >> 1);
      end
    end
  end

  // reference side
  logic [CNT_W-1:0] gs1, gs2, sync_bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs1 <= '0;
      gs2 <= '0;
    end else begin
      gs1 <= gray_q;
      gs2 <= gs1;
    end
  end

  always_comb begin
    sync_bin[CNT_W-1] = gs2[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--)
      sync_bin[i] = sync_bin[i+1] ^ gs2[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      start_d  <= 1'b0;
      done_q   <= 1'b0;
      gate_q   <= 1'b0;
      clr_q    <= 1'b0;
      timer_q  <= '0;
      scnt_q   <= '0;
      result_q <= '0;
    end else begin
      start_d <= active;
      if (start_rise) begin
        state_q <= S_CLR;
        clr_q   <= 1'b1;
        done_q  <= 1'b0;
        gate_q  <= 1'b0;
        timer_q <= win_q;
      end else if (!active) begin
        state_q <= S_IDLE;
        gate_q  <= 1'b0;
        clr_q   <= 1'b0;
      end else begin
        case (state_q)
          S_CLR: begin
            clr_q   <= 1'b0;
            gate_q  <= 1'b1;
            state_q <= S_RUN;
          end
          S_RUN: begin
            if (timer_q <= 32'd1) begin
              gate_q  <= 1'b0;
              scnt_q  <= ST_W'(SETTLE);
              state_q <= S_SET;
            end else begin
              timer_q <= timer_q - 1'b1;
            end
          end
          S_SET: begin
            if (scnt_q <= ST_W'(1)) begin
              result_q <= 32'(sync_bin);
              done_q   <= 1'b1;
              state_q  <= S_IDLE;
            end else begin
              scnt_q <= scnt_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {27'd0, ctrl_q};
      A_WIN:   bus_rdata = win_q;
      A_STAT:  bus_rdata = {31'd0, done_q};
      A_RES:   bus_rdata = result_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/osc_freq_monitor_chk.sv
module osc_freq_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [4:0]  ctrl_q,
  input logic        done_q,
  input logic        gate_q,
  input logic        start_rise,
  input logic [31:0] result_q
);
  // R1
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04 && !bus_wdata[16]) |=> $stable(ctrl_q[0]));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_rise) |=> done_q);

  // R8
  abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] || !ctrl_q[0]) |=> !gate_q);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done_q) |-> $stable(result_q));

  // R5
  gate_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q && done_q));
endmodule

bind osc_freq_monitor osc_freq_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .done_q(done_q), .gate_q(gate_q),
  .start_rise(start_rise), .result_q(result_q)
);

// File: tb/osc_freq_monitor_tb.sv
`timescale 1ns/1ps
module osc_freq_monitor_tb;
  localparam int SETTLE = 8;

  logic        clk = 0, rst_n = 0;
  logic [6:0]  osc = '0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_sat;

  int tests = 0, fails = 0;
  bit ended = 0;

  int    exp_q[$], tol_q[$], act_q[$];
  string tag_q[$];

  always #5 clk = ~clk;
  always #3.5  osc[0] = ~osc[0];
  always #6.5  osc[1] = ~osc[1];
  always #11.5 osc[2] = ~osc[2];
  always #18.5 osc[3] = ~osc[3];
  always #5.5  osc[4] = ~osc[4];
  always #5.5  osc[5] = ~osc[5];
  always #5.5  osc[6] = ~osc[6];

  osc_freq_monitor #(.NUM_OSC(7), .CNT_W(32), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata));

  osc_freq_monitor #(.NUM_OSC(7), .CNT_W(4), .SETTLE(SETTLE)) u_sat (
    .clk(clk), .rst_n(rst_n), .osc_in(osc), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_sat));

  task automatic check(string tag, int act, int exp, int tol);
    int d = act - exp;
    tests++;
    if (d < -tol || d > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
    end
  endtask

  // monitor: pops expected items and compares with results as they appear
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front(), tol_q.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int d, output int s);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = int'(rdata);
    s = int'(rdata_sat);
  endtask

  task automatic expect_item(string tag, int exp, int tol, int act);
    tag_q.push_back(tag); exp_q.push_back(exp); tol_q.push_back(tol);
    act_q.push_back(act);
  endtask

  function automatic logic [31:0] start_word(int sel);
    return 32'h001D_0000 | (32'(sel) << 2) | 32'd1;
  endfunction

  task automatic measure(int sel, int w, output int res, output int sat);
    int d, s, n;
    wr(8'h08, 32'(w));
    wr(8'h04, start_word(sel));
    n = 0;
    do begin rd(8'h80, d, s); n++; end while (d[0] == 0 && n < 5000);
    rd(8'h84, res, sat);
    wr(8'h04, 32'h0001_0000);
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end

  initial begin
    int d, s, res, sat, last;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset values
    rd(8'h04, d, s); expect_item("R2 ctrl", d, 0, 0);
    rd(8'h08, d, s); expect_item("R2 window", d, 0, 0);
    rd(8'h80, d, s); expect_item("R2 status", d, 0, 0);
    rd(8'h84, d, s); expect_item("R2 result", d, 0, 0);
    rd(8'h40, d, s); expect_item("R2 unmapped", d, 0, 0);

    // R1 masked writes
    wr(8'h04, 32'h0000_001F);
    rd(8'h04, d, s); expect_item("R1 zero mask", 0, 0, d);
    wr(8'h04, 32'h0002_FFFF);
    rd(8'h04, d, s); expect_item("R1 enable only", 2, 0, d);

    // R3 window register
    wr(8'h08, 32'hA5C3_0F01);
    rd(8'h08, d, s); expect_item("R3 window", 32'hA5C3_0F01, 0, d);

    // R4 count per oscillator, R11 saturation on narrow counter
    measure(0, 200, res, sat);
    expect_item("R4 osc0", 2000 / 7, 3, res);
    expect_item("R11 saturate", 15, 0, sat);
    measure(1, 200, res, sat); expect_item("R4 osc1", 2000 / 13, 3, res);
    measure(2, 200, res, sat); expect_item("R4 osc2", 2000 / 23, 3, res);
    measure(3, 200, res, sat); expect_item("R4 osc3", 2000 / 37, 3, res);
    measure(4, 400, res, sat); expect_item("R4 osc4 long", 4000 / 11, 3, res);

    // R10 invalid select
    measure(7, 200, res, sat); expect_item("R10 sel7", 0, 0, res);
    measure(3, 200, last, sat);

    // R5 exact done timing
    wr(8'h08, 32'd50);
    wr(8'h04, start_word(1));
    bus_addr = 8'h80;
    repeat (1 + 50 + SETTLE) @(negedge clk);
    #1; expect_item("R5 done early", 0, 0, int'(rdata));
    @(negedge clk);
    #1; expect_item("R5 done on time", 1, 0, int'(rdata));

    // R6 restart clears done
    wr(8'h04, 32'h0001_0000);
    wr(8'h04, start_word(1));
    rd(8'h80, d, s); expect_item("R6 done cleared", 0, 0, d);
    repeat (80) @(negedge clk);
    rd(8'h84, last, s);
    wr(8'h04, 32'h0001_0000);

    // R8 abort mid-window
    wr(8'h08, 32'd1000);
    wr(8'h04, start_word(0));
    repeat (100) @(negedge clk);
    wr(8'h04, 32'h0001_0000);
    repeat (1200) @(negedge clk);
    rd(8'h80, d, s); expect_item("R8 abort done", 0, 0, d);
    rd(8'h84, d, s); expect_item("R8 abort result", last, 0, d);

    // R7 start with enable low
    wr(8'h04, 32'h0002_0000);
    wr(8'h08, 32'd20);
    wr(8'h04, 32'h0001_0001);
    repeat (60) @(negedge clk);
    rd(8'h80, d, s); expect_item("R7 no done", 0, 0, d);
    rd(8'h84, d, s); expect_item("R7 result kept", last, 0, d);
    wr(8'h04, 32'h0003_0002);

    // R9 clear one edge before capture: abort
    wr(8'h04, start_word(0));
    repeat (20 + SETTLE - 1) @(negedge clk);
    wr(8'h04, 32'h0001_0000);
    repeat (20) @(negedge clk);
    rd(8'h80, d, s); expect_item("R9 early clear", 0, 0, d);
    rd(8'h84, d, s); expect_item("R9 early result", last, 0, d);

    // R9 clear on the capture edge: completes
    wr(8'h04, start_word(0));
    repeat (20 + SETTLE) @(negedge clk);
    wr(8'h04, 32'h0001_0000);
    repeat (20) @(negedge clk);
    rd(8'h80, d, s); expect_item("R9 same edge done", 1, 0, d);
    rd(8'h84, d, s); expect_item("R9 same edge count", 200 / 7, 3, d);

    repeat (5) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end
endmodule